// File: doc/BRIEF.md
# Exponential ADSR envelope generator

This block shapes the loudness of one synthesizer voice. A gate input starts a note (attack, then decay to a sustain level) and ends it (release to silence). The output is an 8-bit envelope level plus a 2-bit phase code. Attack rises in equal steps. Decay and release slow down as the level falls, so they trace an approximately exponential curve.

Two 8-bit rate bytes set the timing. The attack/decay byte holds the attack rate in its upper nibble and the decay rate in its lower nibble. The sustain/release byte holds the sustain level in its upper nibble and the release rate in its lower nibble. A free-running 15-bit rate counter produces a tick each time it reaches the period selected for the current phase. During decay and release, a level-keyed exponent divider thins those ticks out further. The block advances only on cycles where the clock enable is high, and one enable pulse stands for one chip cycle.

Top module: `env_shaper`

## Requirements
- R1: A synchronous active-high reset sets the level to 0 and the phase to idle. Phase codes are 0 = idle, 1 = attack, 2 = decay/sustain, 3 = release.
- R2: In a cycle where the clock enable is low, the level, the phase and all internal counters keep their values, and gate changes are not sampled.
- R3: The rate counter is 15 bits wide and wraps at 0x8000. It counts enabled cycles. When it reaches the selected period it returns to 0 and produces a tick. The period for rate nibble 0..15 is 9, 32, 63, 95, 149, 220, 267, 313, 392, 977, 1954, 3126, 3907, 11720, 19532, 31251 cycles. The attack nibble is atk_dec[7:4], the decay nibble is atk_dec[3:0] and the release nibble is sus_rel[3:0]. The counter is not cleared by gate changes.
- R4: When the sampled gate goes from low to high, the phase becomes attack in the same enabled cycle. When it goes from high to low, the phase becomes release, or idle if the level had already been frozen at 0.
- R5: In attack, every tick raises the level by 1 without using the exponent divider. When the level reaches 0xFF, the phase changes to decay/sustain.
- R6: In decay and release, a step is taken only on the Nth tick, where N depends on the current level: 1 at level 0, 30 at 1..6, 16 at 7..14, 8 at 15..26, 4 at 27..54, 2 at 55..93 and 1 at 94..255. The divider restarts from 0 after every step.
- R7: Decay lowers the level until it equals the sustain nibble copied into both halves of a byte (sus_rel[7:4] × 17). The level then holds while the gate stays high.
- R8: Release lowers the level. On reaching 0 the phase becomes idle, and the level stays at 0 until the next rising gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable, one pulse per chip cycle |
| gate | input | 1 | Note gate |
| atk_dec | input | 8 | Attack rate [7:4], decay rate [3:0] |
| sus_rel | input | 8 | Sustain level [7:4], release rate [3:0] |
| env_level | output | 8 | Envelope level |
| phase | output | 2 | 0 idle, 1 attack, 2 decay/sustain, 3 release |

## Verification
The bench times the first attack step exactly, which exposes a wrong period table entry or an off-by-one in the rate counter that shifts every step by one cycle. It also times the dwell at levels 6 and 20 during release. A divider keyed on the wrong level, or one that is not restarted after a step, would stretch or shorten those dwells. It checks that decay stops exactly at the nibble×17 sustain level; comparing against the raw nibble would let the level fall almost to silence. It checks that a released note parks at 0 in idle rather than wrapping to 0xFF. Random gate and enable traffic is compared cycle by cycle against a bench model, including gate edges that arrive while the rate counter sits above the new period.

// File: rtl/env_pkg.sv
package env_pkg;
    localparam int ENV_LVL_W  = 8;
    localparam int ENV_NIB_W  = ENV_LVL_W / 2;
    localparam int ENV_RATE_W = 15;
    localparam int ENV_EXP_W  = 5;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ATTACK  = 2'd1,
        PH_DECAY   = 2'd2,
        PH_RELEASE = 2'd3
    } env_phase_e;

    typedef struct packed {
        logic gate_seen;
        logic rising;
        logic falling_ok;
        logic live;
    } env_flags_t;

    typedef struct packed {
        env_flags_t               fl;
        logic [ENV_LVL_W-1:0]     lvl;
        logic [ENV_EXP_W-1:0]     ex;
    } env_state_t;
endpackage

// File: rtl/env_rate_sel.sv
module env_rate_sel
    import env_pkg::*;
(
    input  logic [ENV_NIB_W-1:0]  nib,
    output logic [ENV_RATE_W-1:0] period
);
    always_comb begin
        unique case (nib)
            4'd0:    period = ENV_RATE_W'(9);
            4'd1:    period = ENV_RATE_W'(32);
            4'd2:    period = ENV_RATE_W'(63);
            4'd3:    period = ENV_RATE_W'(95);
            4'd4:    period = ENV_RATE_W'(149);
            4'd5:    period = ENV_RATE_W'(220);
            4'd6:    period = ENV_RATE_W'(267);
            4'd7:    period = ENV_RATE_W'(313);
            4'd8:    period = ENV_RATE_W'(392);
            4'd9:    period = ENV_RATE_W'(977);
            4'd10:   period = ENV_RATE_W'(1954);
            4'd11:   period = ENV_RATE_W'(3126);
            4'd12:   period = ENV_RATE_W'(3907);
            4'd13:   period = ENV_RATE_W'(11720);
            4'd14:   period = ENV_RATE_W'(19532);
            default: period = ENV_RATE_W'(31251);
        endcase
    end
endmodule

// File: rtl/env_slope_sel.sv
module env_slope_sel
    import env_pkg::*;
(
    input  logic [ENV_LVL_W-1:0] lvl,
    output logic [ENV_EXP_W-1:0] div_n
);
    localparam int EDGE_A = 6;
    localparam int EDGE_B = 14;
    localparam int EDGE_C = 26;
    localparam int EDGE_D = 54;
    localparam int EDGE_E = 93;

    always_comb begin
        if (lvl == '0)                         div_n = ENV_EXP_W'(1);
        else if (lvl <= ENV_LVL_W'(EDGE_A))    div_n = ENV_EXP_W'(30);
        else if (lvl <= ENV_LVL_W'(EDGE_B))    div_n = ENV_EXP_W'(16);
        else if (lvl <= ENV_LVL_W'(EDGE_C))    div_n = ENV_EXP_W'(8);
        else if (lvl <= ENV_LVL_W'(EDGE_D))    div_n = ENV_EXP_W'(4);
        else if (lvl <= ENV_LVL_W'(EDGE_E))    div_n = ENV_EXP_W'(2);
        else                                   div_n = ENV_EXP_W'(1);
    end
endmodule

// File: rtl/env_rate_timer.sv
module env_rate_timer
    import env_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce,
    input  logic [ENV_RATE_W-1:0] period,
    output logic                  tick
);
    logic [ENV_RATE_W-1:0] cnt_d, cnt_q;
    logic [ENV_RATE_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        tick    = ce && (cnt_inc == period);
        cnt_d   = cnt_q;
        if (ce) begin
            cnt_d = tick ? '0 : cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/env_shaper.sv
module env_shaper
    import env_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce,
    input  logic                 gate,
    input  logic [ENV_LVL_W-1:0] atk_dec,
    input  logic [ENV_LVL_W-1:0] sus_rel,
    output logic [ENV_LVL_W-1:0] env_level,
    output logic [1:0]           phase
);
    env_state_t              st_d, st_q;
    env_flags_t              fl_e;
    logic [ENV_NIB_W-1:0]    rate_nib;
    logic [ENV_RATE_W-1:0]   rate_per;
    logic                    tick;
    logic [ENV_EXP_W-1:0]    div_n;
    logic [ENV_LVL_W-1:0]    floor_lvl;
    env_phase_e              ph;

    // gate edge handling and rate selection
    always_comb begin
        fl_e = st_q.fl;
        if (ce && (gate != st_q.fl.gate_seen)) begin
            if (st_q.fl.gate_seen) begin
                fl_e.gate_seen  = 1'b0;
                fl_e.rising     = 1'b0;
                fl_e.falling_ok = 1'b0;
            end else begin
                fl_e = '{gate_seen: 1'b1, rising: 1'b1, falling_ok: 1'b1, live: 1'b1};
            end
        end
        if (fl_e.rising)          rate_nib = atk_dec[ENV_LVL_W-1:ENV_NIB_W];
        else if (fl_e.falling_ok) rate_nib = atk_dec[ENV_NIB_W-1:0];
        else                      rate_nib = sus_rel[ENV_NIB_W-1:0];
    end

    env_rate_sel u_rate_sel (
        .nib    (rate_nib),
        .period (rate_per)
    );

    env_rate_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .period (rate_per),
        .tick   (tick)
    );

    env_slope_sel u_slope (
        .lvl   (st_q.lvl),
        .div_n (div_n)
    );

    // level and divider update
    always_comb begin
        floor_lvl = {sus_rel[ENV_LVL_W-1:ENV_NIB_W], sus_rel[ENV_LVL_W-1:ENV_NIB_W]};
        st_d      = st_q;
        if (ce) begin
            st_d.fl = fl_e;
            if (tick) begin
                if (fl_e.rising || (ENV_EXP_W'(st_q.ex + 1'b1) == div_n)) begin
                    st_d.ex = '0;
                    if (fl_e.live) begin
                        if (fl_e.rising) begin
                            st_d.lvl = st_q.lvl + 1'b1;
                            if (st_d.lvl == '1) st_d.fl.rising = 1'b0;
                        end else if (!fl_e.falling_ok || (st_q.lvl != floor_lvl)) begin
                            st_d.lvl = st_q.lvl - 1'b1;
                            if (st_d.lvl == '0) st_d.fl.live = 1'b0;
                        end
                    end
                end else begin
                    st_d.ex = st_q.ex + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        if (st_q.fl.rising)          ph = PH_ATTACK;
        else if (st_q.fl.falling_ok) ph = PH_DECAY;
        else if (st_q.fl.live)       ph = PH_RELEASE;
        else                         ph = PH_IDLE;
        env_level = st_q.lvl;
        phase     = ph;
    end
endmodule

// File: rtl/env_shaper_chk.sv
module env_shaper_chk (
    input logic       clk,
    input logic       rst,
    input logic       ce,
    input logic       gate,
    input logic [7:0] atk_dec,
    input logic [7:0] sus_rel,
    input logic [7:0] env_level,
    input logic [1:0] phase
);
    assert_hold_no_ce_R2: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(env_level) && $stable(phase)));

    assert_rise_to_attack_R4: assert property (@(posedge clk) disable iff (rst)
        (ce && gate && (phase == 2'd0 || phase == 2'd3)) |=> (phase == 2'd1 || phase == 2'd2));

    assert_fall_to_release_R4: assert property (@(posedge clk) disable iff (rst)
        (ce && !gate && (phase == 2'd1 || phase == 2'd2)) |=> (phase == 2'd3 || phase == 2'd0));

    assert_attack_climbs_R5: assert property (@(posedge clk) disable iff (rst)
        (ce && gate && phase == 2'd1) |=> (env_level == $past(env_level) || env_level == $past(env_level) + 8'd1));

    assert_sustain_floor_R7: assert property (@(posedge clk) disable iff (rst)
        (ce && gate && phase == 2'd2 && env_level == {sus_rel[7:4], sus_rel[7:4]}) |=> $stable(env_level));

    assert_idle_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0) |-> (env_level == 8'd0));

    assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
        ce |=> (env_level == $past(env_level) || env_level == $past(env_level) + 8'd1 ||
                env_level == $past(env_level) - 8'd1));
endmodule

bind env_shaper env_shaper_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .gate      (gate),
    .atk_dec   (atk_dec),
    .sus_rel   (sus_rel),
    .env_level (env_level),
    .phase     (phase)
);

// File: tb/sim_env_shaper.sv
module sim_env_shaper;
    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce = 1'b0;
    logic       gate = 1'b0;
    logic [7:0] atk_dec = '0;
    logic [7:0] sus_rel = '0;
    logic [7:0] env_level;
    logic [1:0] phase;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_rc, m_ex, m_env;
    bit m_g, m_a, m_d, m_h;

    always #(CLK_PER/2) clk = ~clk;

    env_shaper u0 (
        .clk(clk), .rst(rst), .ce(ce), .gate(gate),
        .atk_dec(atk_dec), .sus_rel(sus_rel),
        .env_level(env_level), .phase(phase)
    );

    function automatic int prescale(int n);
        case (n)
            0: return 9;     1: return 32;    2: return 63;    3: return 95;
            4: return 149;   5: return 220;   6: return 267;   7: return 313;
            8: return 392;   9: return 977;   10: return 1954; 11: return 3126;
            12: return 3907; 13: return 11720; 14: return 19532; default: return 31251;
        endcase
    endfunction

    function automatic int slope(int l);
        if (l == 0) return 1;
        if (l <= 6) return 30;
        if (l <= 14) return 16;
        if (l <= 26) return 8;
        if (l <= 54) return 4;
        if (l <= 93) return 2;
        return 1;
    endfunction

    function automatic void model_reset();
        m_rc = 0; m_ex = 0; m_env = 0;
        m_g = 0; m_a = 0; m_d = 0; m_h = 0;
    endfunction

    function automatic int model_phase();
        if (m_a) return 1;
        if (m_d) return 2;
        if (m_h) return 3;
        return 0;
    endfunction

    function automatic void model_step(bit g, int ad, int sr, bit c);
        int per;
        if (!c) return;
        if (g != m_g) begin
            if (m_g) begin m_g = 0; m_a = 0; m_d = 0; end
            else begin m_g = 1; m_a = 1; m_d = 1; m_h = 1; end
        end
        per = m_a ? prescale(ad / 16) : (m_d ? prescale(ad % 16) : prescale(sr % 16));
        m_rc = (m_rc + 1) % 32768;
        if (m_rc == per) begin
            m_rc = 0;
            if (m_a || (m_ex + 1) == slope(m_env)) begin
                m_ex = 0;
                if (m_h) begin
                    if (m_a) begin
                        m_env = (m_env + 1) % 256;
                        if (m_env == 255) m_a = 0;
                    end else if (!m_d || m_env != (sr / 16) * 17) begin
                        m_env = (m_env + 255) % 256;
                        if (m_env == 0) m_h = 0;
                    end
                end
            end else begin
                m_ex = m_ex + 1;
            end
        end
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one enabled-or-not cycle: compare against model, then drive
    task automatic cyc(bit g, logic [7:0] ad, logic [7:0] sr, bit c);
        @(negedge clk);
        check("R3 R5 R6 R7 level vs model", int'(env_level), m_env);
        check("R4 R8 phase vs model", int'(phase), model_phase());
        gate = g; atk_dec = ad; sus_rel = sr; ce = c;
        model_step(g, int'(ad), int'(sr), c);
    endtask

    task automatic peek();
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (400000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int t6, t20, seen6, seen20;
        process::self().srandom(32'd1234);
        model_reset();
        repeat (4) @(negedge clk);
        @(negedge clk);
        check("R1 level after reset", int'(env_level), 0);
        check("R1 phase after reset", int'(phase), 0);
        rst = 1'b0;

        // R3 attack nibble 1 -> 32 cycles per step; sustain A, decay/release nibble 0
        for (int i = 0; i < 31; i++) cyc(1, 8'h10, 8'hA0, 1);
        peek();
        check("R3 no step before period", int'(env_level), 0);
        check("R4 phase attack after rise", int'(phase), 1);
        cyc(1, 8'h10, 8'hA0, 1);
        peek();
        check("R3 first step at period", int'(env_level), 1);
        for (int i = 0; i < 8127; i++) cyc(1, 8'h10, 8'hA0, 1);
        peek();
        check("R5 level one below top", int'(env_level), 254);
        check("R5 still attack", int'(phase), 1);
        cyc(1, 8'h10, 8'hA0, 1);
        peek();
        check("R5 top reached", int'(env_level), 255);
        check("R5 phase decay after top", int'(phase), 2);

        // R7 decay with nibble 0 period 9 down to 0xAA
        for (int i = 0; i < 764; i++) cyc(1, 8'h10, 8'hA0, 1);
        peek();
        check("R7 one above sustain", int'(env_level), 8'hAB);
        cyc(1, 8'h10, 8'hA0, 1);
        peek();
        check("R7 sustain reached", int'(env_level), 8'hAA);
        for (int i = 0; i < 300; i++) cyc(1, 8'h10, 8'hA0, 1);
        peek();
        check("R7 sustain held", int'(env_level), 8'hAA);
        check("R7 phase decay held", int'(phase), 2);

        // R2 enable low freezes
        for (int i = 0; i < 40; i++) cyc(0, 8'h10, 8'hA0, 0);
        peek();
        check("R2 level frozen", int'(env_level), 8'hAA);
        check("R2 gate fall ignored", int'(phase), 2);

        // release, time dwell at levels 20 and 6 (R6)
        t6 = 0; t20 = 0; seen6 = 0; seen20 = 0;
        for (int i = 0; i < 9000; i++) begin
            cyc(0, 8'h10, 8'hA0, 1);
            peek();
            if (env_level == 8'd20) begin seen20 = 1; t20++; end
            if (env_level == 8'd6)  begin seen6 = 1;  t6++;  end
        end
        check("R6 dwell at level 20", t20, 72);
        check("R6 dwell at level 6", t6, 270);
        check("R8 level zero after release", int'(env_level), 0);
        check("R8 phase idle", int'(phase), 0);
        for (int i = 0; i < 500; i++) cyc(0, 8'h10, 8'hA0, 1);
        peek();
        check("R8 frozen at zero", int'(env_level), 0);

        // random traffic against model
        for (int seg = 0; seg < 30; seg++) begin
            int n;
            logic [7:0] ad, sr;
            bit g;
            n  = $urandom_range(0, 2);
            ad = {4'(n), 4'($urandom_range(0, 2))};
            sr = {4'($urandom_range(0, 15)), 4'($urandom_range(0, 2))};
            g  = gate;
            for (int i = 0; i < 2000; i++) begin
                if ($urandom_range(0, 399) == 0) g = ~g;
                cyc(g, ad, sr, ($urandom_range(0, 7) != 0));
            end
        end

        cyc(gate, atk_dec, sus_rel, 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule